// File: doc/BRIEF.md
# Critical Section Request Buffer

This block sits between a set of small cores and the one large core that runs critical sections on their behalf. A small core that reaches a critical section does not take the lock itself. It offers a call request on its own port. The request carries the lock address, the entry program counter of the critical section and the caller's stack pointer. The buffer stores the request together with the index of the port it came in on. Requests wait in arrival order while the large core is busy, and they are handed over one at a time.

When the large core finishes a critical section and its return, it reports a completion that carries the lock address. The buffer compares that address with the request currently in service. On a match, it pulses a done response on the originating core's response line only, and that core may then resume. A completion that does not match anything in service is dropped and latches an error flag. Because only the large core ever runs buffered sections, the locks stay in that core's caches and do not move between the small cores.

Top module: `cs_request_buffer`

## Requirements
- R1: A request on core port i is accepted in a cycle where `req_valid[i]` and `req_ready[i]` are both high. The stored entry keeps that cycle's lock, program counter and stack pointer, plus the port index i as the core ID.
- R2: At most one request is accepted per cycle. Among eligible cores, priority rotates: after reset core 0 ranks first, and after a grant to core g the search starts at core g+1 (mod the core count).
- R3: While the buffer holds DEPTH entries, every `req_ready` bit is low.
- R4: A core with an accepted request whose done response has not yet been issued sees `req_ready` low for that core, even when space is free.
- R5: Entries go to the large core in acceptance order. `exec_lock`, `exec_pc`, `exec_sp` and `exec_core` show the oldest entry while `exec_valid` is high, and the entry leaves the buffer on a cycle with `exec_valid` and `exec_ready` both high.
- R6: After a hand-over, `exec_valid` stays low until a matching completion has been taken, so at most one request is in service.
- R7: A completion (`done_valid` high) whose `done_lock` equals the in-service lock causes `resp_valid` to go high for one cycle, one cycle later, on the bit of the in-service core only. `resp_lock` then equals that lock. The core becomes eligible again from the cycle after the completion.
- R8: A completion whose lock differs from the in-service lock, or that arrives with nothing in service, is dropped. It gives no response, leaves the service state unchanged and sets `err_sticky`, which stays high until reset.
- R9: A synchronous active-high `rst` empties the buffer, clears the in-service state, the outstanding marks, the responses and `err_sticky`, and resets the priority to core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core call request valid |
| req_lock | input | NUM_CORES*LOCK_W | Per-core lock address, core i in slice i |
| req_pc | input | NUM_CORES*PC_W | Per-core critical section entry PC |
| req_sp | input | NUM_CORES*SP_W | Per-core stack pointer |
| req_ready | output | NUM_CORES | Per-core acceptance |
| exec_valid | output | 1 | Oldest entry offered to the large core |
| exec_ready | input | 1 | Large core takes the offered entry |
| exec_lock | output | LOCK_W | Offered lock address |
| exec_pc | output | PC_W | Offered entry PC |
| exec_sp | output | SP_W | Offered stack pointer |
| exec_core | output | CORE_W | Offered requester index |
| done_valid | input | 1 | Completion from the large core |
| done_lock | input | LOCK_W | Lock address of the completion |
| resp_valid | output | NUM_CORES | One-cycle done pulse per core |
| resp_lock | output | LOCK_W | Lock address of the done response |
| err_sticky | output | 1 | Latched unmatched-completion error |

## Verification
The bench first goes after the cycle where all cores request at once with the large core stalled. A wrong rotation gives grants in the wrong order. A full buffer that still asserts ready overwrites the oldest entry, and a stale outstanding mark lets a core queue two calls. Completions carrying a wrong lock, and completions sent while nothing is in service, are aimed at designs that answer the wrong core, clear the service slot early or fail to latch the error. A reset in the middle of traffic exposes entries or marks that survive reset. Long random traffic with back-pressure from the large core checks the dispatch order, the content of each field and the timing of the response pulse every cycle.

// File: rtl/cs_buf_pkg.sv
package cs_buf_pkg;

   typedef enum logic {
      SVC_IDLE = 1'b0,
      SVC_BUSY = 1'b1
   } svc_state_t;

endpackage

// File: rtl/cs_rr_arbiter.sv
module cs_rr_arbiter #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [N-1:0] elig,
   output logic [N-1:0] grant
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] ptr;
   int            gidx;

   always_comb begin
      grant = '0;
      gidx  = 0;
      for (int o = 0; o < N; o++) begin
         int idx;
         idx = (int'(ptr) + o) % N;
         if (en && (grant == '0) && elig[idx]) begin
            grant[idx] = 1'b1;
            gidx       = idx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr <= '0;
      end else if (grant != '0) begin
         ptr <= (gidx == N - 1) ? '0 : IW'(gidx + 1);
      end
   end

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant));

endmodule

// File: rtl/cs_entry_fifo.sv
module cs_entry_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] count;

   generate
      if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      full |-> !push);
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      empty |-> !pop);

endmodule

// File: rtl/cs_service_tracker.sv
module cs_service_tracker
   import cs_buf_pkg::*;
#(
   parameter int N      = 4,
   parameter int LOCK_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [((N > 1) ? $clog2(N) : 1)-1:0] start_core,
   input  logic [LOCK_W-1:0] start_lock,
   input  logic              done_valid,
   input  logic [LOCK_W-1:0] done_lock,
   output logic              busy,
   output logic [N-1:0]      clear_mask,
   output logic [N-1:0]      resp_valid,
   output logic [LOCK_W-1:0] resp_lock,
   output logic              err
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   svc_state_t        state;
   logic [IW-1:0]     core_q;
   logic [LOCK_W-1:0] lock_q;
   logic              match;

   assign busy       = (state == SVC_BUSY);
   assign match      = done_valid && busy && (done_lock == lock_q);
   assign clear_mask = match ? (N'(1) << core_q) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= SVC_IDLE;
         core_q     <= '0;
         lock_q     <= '0;
         resp_valid <= '0;
         resp_lock  <= '0;
         err        <= 1'b0;
      end else begin
         resp_valid <= clear_mask;
         if (match) resp_lock <= lock_q;
         if (done_valid && !match) err <= 1'b1;
         if (match) begin
            state <= SVC_IDLE;
         end else if (start) begin
            state  <= SVC_BUSY;
            core_q <= start_core;
            lock_q <= start_lock;
         end
      end
   end

   assert_single_service_R6: assert property (@(posedge clk) disable iff (rst)
      start |-> state == SVC_IDLE);
   assert_resp_onehot_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(resp_valid));
   assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      (resp_valid != '0) |=> (resp_valid == '0));
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      err |=> err);

endmodule

// File: rtl/cs_request_buffer.sv
module cs_request_buffer #(
   parameter int NUM_CORES = 4,
   parameter int DEPTH     = 4,
   parameter int LOCK_W    = 16,
   parameter int PC_W      = 16,
   parameter int SP_W      = 16,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_CORES-1:0]        req_valid,
   input  logic [NUM_CORES*LOCK_W-1:0] req_lock,
   input  logic [NUM_CORES*PC_W-1:0]   req_pc,
   input  logic [NUM_CORES*SP_W-1:0]   req_sp,
   output logic [NUM_CORES-1:0]        req_ready,
   output logic                        exec_valid,
   input  logic                        exec_ready,
   output logic [LOCK_W-1:0]           exec_lock,
   output logic [PC_W-1:0]             exec_pc,
   output logic [SP_W-1:0]             exec_sp,
   output logic [CORE_W-1:0]           exec_core,
   input  logic                        done_valid,
   input  logic [LOCK_W-1:0]           done_lock,
   output logic [NUM_CORES-1:0]        resp_valid,
   output logic [LOCK_W-1:0]           resp_lock,
   output logic                        err_sticky
);
   localparam int EW = CORE_W + SP_W + PC_W + LOCK_W;

   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("cs_request_buffer: NUM_CORES must be at least 2");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("cs_request_buffer: DEPTH must be at least 1");
      end
      if (LOCK_W < 1 || PC_W < 1 || SP_W < 1) begin : g_bad_width
         $error("cs_request_buffer: field widths must be positive");
      end
   endgenerate

   logic [NUM_CORES-1:0] outstanding, elig, grant, clear_mask;
   logic [EW-1:0]        din, head;
   logic                 empty, full, busy, fire;

   assign elig      = req_valid & ~outstanding;
   assign req_ready = grant;

   cs_rr_arbiter #(.N(NUM_CORES)) u_arb (
      .clk   (clk),
      .rst   (rst),
      .en    (!full),
      .elig  (elig),
      .grant (grant)
   );

   always_comb begin
      din = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (grant[i]) begin
            din = {CORE_W'(i), req_sp[i*SP_W +: SP_W],
                   req_pc[i*PC_W +: PC_W], req_lock[i*LOCK_W +: LOCK_W]};
         end
      end
   end

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      always_ff @(posedge clk) begin
         if (rst)                outstanding[g] <= 1'b0;
         else if (grant[g])      outstanding[g] <= 1'b1;
         else if (clear_mask[g]) outstanding[g] <= 1'b0;
      end

      assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
         outstanding[g] |-> !req_ready[g]);
   end

   cs_entry_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (grant != '0),
      .din   (din),
      .pop   (fire),
      .head  (head),
      .empty (empty),
      .full  (full)
   );

   assign exec_valid = !empty && !busy;
   assign fire       = exec_valid && exec_ready;
   assign {exec_core, exec_sp, exec_pc, exec_lock} = head;

   cs_service_tracker #(.N(NUM_CORES), .LOCK_W(LOCK_W)) u_svc (
      .clk        (clk),
      .rst        (rst),
      .start      (fire),
      .start_core (exec_core),
      .start_lock (exec_lock),
      .done_valid (done_valid),
      .done_lock  (done_lock),
      .busy       (busy),
      .clear_mask (clear_mask),
      .resp_valid (resp_valid),
      .resp_lock  (resp_lock),
      .err        (err_sticky)
   );

   assert_full_refuse_R3: assert property (@(posedge clk) disable iff (rst)
      full |-> (req_ready == '0));
   assert_resp_owner_R7: assert property (@(posedge clk) disable iff (rst)
      (clear_mask != '0) |-> ((clear_mask & outstanding) == clear_mask));

endmodule

// File: tb/cs_request_buffer_test.sv
module cs_request_buffer_test;
   localparam int NC = 4;
   localparam int DP = 3;
   localparam int LW = 12;
   localparam int PW = 16;
   localparam int SW = 16;
   localparam int CW = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NC-1:0]    req_valid = '0;
   logic [NC*LW-1:0] req_lock  = '0;
   logic [NC*PW-1:0] req_pc    = '0;
   logic [NC*SW-1:0] req_sp    = '0;
   logic [NC-1:0]    req_ready;
   logic             exec_valid;
   logic             exec_ready = 1'b0;
   logic [LW-1:0]    exec_lock;
   logic [PW-1:0]    exec_pc;
   logic [SW-1:0]    exec_sp;
   logic [CW-1:0]    exec_core;
   logic             done_valid = 1'b0;
   logic [LW-1:0]    done_lock  = '0;
   logic [NC-1:0]    resp_valid;
   logic [LW-1:0]    resp_lock;
   logic             err_sticky;

   always #2 clk = ~clk;

   cs_request_buffer #(.NUM_CORES(NC), .DEPTH(DP), .LOCK_W(LW), .PC_W(PW), .SP_W(SW)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_lock(req_lock), .req_pc(req_pc),
      .req_sp(req_sp), .req_ready(req_ready), .exec_valid(exec_valid), .exec_ready(exec_ready),
      .exec_lock(exec_lock), .exec_pc(exec_pc), .exec_sp(exec_sp), .exec_core(exec_core),
      .done_valid(done_valid), .done_lock(done_lock), .resp_valid(resp_valid),
      .resp_lock(resp_lock), .err_sticky(err_sticky)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // reference model state
   logic [NC-1:0] m_out, m_resp;
   int            m_ptr, m_svc_core;
   bit            m_busy, m_err;
   logic [LW-1:0] m_svc_lock, m_resp_lock;
   int            qc[$];
   logic [LW-1:0] ql[$];
   logic [PW-1:0] qp[$];
   logic [SW-1:0] qs[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int pick(input logic [NC-1:0] v);
      if (qc.size() >= DP) return -1;
      for (int o = 0; o < NC; o++) begin
         int idx;
         idx = (m_ptr + o) % NC;
         if (v[idx] && !m_out[idx]) return idx;
      end
      return -1;
   endfunction

   task automatic model_clear();
      m_out = '0; m_resp = '0; m_ptr = 0; m_svc_core = 0;
      m_busy = 1'b0; m_err = 1'b0; m_svc_lock = '0; m_resp_lock = '0;
      qc.delete(); ql.delete(); qp.delete(); qs.delete();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req_valid = '0; exec_ready = 1'b0; done_valid = 1'b0;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R9: cleared state after reset
      chk(exec_valid == 1'b0, "R9", "exec_valid after reset", 64'(exec_valid), 0);
      chk(resp_valid == '0, "R9", "resp_valid after reset", 64'(resp_valid), 0);
      chk(err_sticky == 1'b0, "R9", "err_sticky after reset", 64'(err_sticky), 0);
   endtask

   task automatic step(input logic [NC-1:0] v, input bit er, input bit dv, input bit bad);
      int g;
      logic [NC-1:0] exp_rdy;
      bit exp_ev;
      string tag;
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         req_lock[c*LW +: LW] = LW'($urandom);
         req_pc[c*PW +: PW]   = PW'($urandom);
         req_sp[c*SW +: SW]   = SW'($urandom);
      end
      req_valid  = v;
      exec_ready = er;
      done_valid = dv;
      done_lock  = bad ? (m_svc_lock ^ LW'(1)) : m_svc_lock;
      #1;
      g = pick(v);
      exp_rdy = (g >= 0) ? (NC'(1) << g) : '0;
      if (qc.size() >= DP && v != '0) tag = "R3";
      else if ((v & m_out) != '0)     tag = "R4";
      else                            tag = "R2";
      chk(req_ready == exp_rdy, tag, "req_ready", 64'(req_ready), 64'(exp_rdy));
      exp_ev = (qc.size() > 0) && !m_busy;
      chk(exec_valid == exp_ev, "R6", "exec_valid", 64'(exec_valid), 64'(exp_ev));
      if (exp_ev) begin
         chk(exec_core == CW'(qc[0]), "R1", "exec_core", 64'(exec_core), 64'(qc[0]));
         chk(exec_lock == ql[0], "R5", "exec_lock", 64'(exec_lock), 64'(ql[0]));
         chk(exec_pc == qp[0], "R5", "exec_pc", 64'(exec_pc), 64'(qp[0]));
         chk(exec_sp == qs[0], "R5", "exec_sp", 64'(exec_sp), 64'(qs[0]));
      end
      chk(resp_valid == m_resp, "R7", "resp_valid", 64'(resp_valid), 64'(m_resp));
      if (m_resp != '0)
         chk(resp_lock == m_resp_lock, "R7", "resp_lock", 64'(resp_lock), 64'(m_resp_lock));
      chk(err_sticky == m_err, "R8", "err_sticky", 64'(err_sticky), 64'(m_err));
      @(posedge clk);
      // model update with the values present before this edge
      m_resp = '0;
      if (dv) begin
         if (m_busy && done_lock == m_svc_lock) begin
            m_resp      = NC'(1) << m_svc_core;
            m_resp_lock = m_svc_lock;
            m_out[m_svc_core] = 1'b0;
            m_busy = 1'b0;
         end else begin
            m_err = 1'b1;
         end
      end
      if (g >= 0) begin
         qc.push_back(g);
         ql.push_back(req_lock[g*LW +: LW]);
         qp.push_back(req_pc[g*PW +: PW]);
         qs.push_back(req_sp[g*SW +: SW]);
         m_out[g] = 1'b1;
         m_ptr = (g + 1) % NC;
      end
      if (exp_ev && er) begin
         m_busy = 1'b1;
         m_svc_core = qc.pop_front();
         m_svc_lock = ql.pop_front();
         void'(qp.pop_front());
         void'(qs.pop_front());
      end
   endtask

   task automatic drain();
      for (int k = 0; k < 100 && (m_busy || qc.size() > 0); k++)
         step('0, 1'b1, m_busy, 1'b0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_clear();
      do_reset();

      // R2 R3: all cores at once with the large core stalled
      for (int k = 0; k < 5; k++) step('1, 1'b0, 1'b0, 1'b0);
      // R4: a granted core keeps requesting after space opens
      step('1, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) step(4'b0001, 1'b1, 1'b0, 1'b0);
      step('1, 1'b1, 1'b1, 1'b0);   // R7 matching completion
      step('1, 1'b1, 1'b0, 1'b0);
      drain();

      // random traffic
      for (int k = 0; k < 3000; k++)
         step(NC'($urandom), ($urandom % 3) != 0, m_busy && ($urandom % 4 == 0), 1'b0);
      drain();

      // R8: wrong lock while busy, then the right one
      step(4'b0100, 1'b1, 1'b0, 1'b0);
      step(4'b0000, 1'b1, 1'b0, 1'b0);
      step(4'b0000, 1'b0, 1'b1, 1'b1);
      step(4'b0000, 1'b0, 1'b0, 1'b0);
      step(4'b0000, 1'b0, 1'b1, 1'b0);
      step(4'b0000, 1'b0, 1'b0, 1'b0);

      // R8: completion with nothing in service
      do_reset();
      step('0, 1'b0, 1'b1, 1'b0);
      step('0, 1'b0, 1'b0, 1'b0);

      // R9: reset in the middle of traffic
      do_reset();
      for (int k = 0; k < 4; k++) step('1, 1'b1, 1'b0, 1'b0);
      do_reset();
      step('1, 1'b0, 1'b0, 1'b0);   // R9 priority back at core 0
      step('0, 1'b0, 1'b0, 1'b0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule